// File: doc/BRIEF.md
# Pixel-Clock PLL Safe Reprogramming Sequencer

This block holds the 64-bit control word of a pixel-clock PLL and drives each of its fields to the PLL. When it gets a start pulse it applies new divider settings (reference divider, loop multiplier, output divider) through a fixed safe sequence. The PLL is first bypassed and powered down. The new values are then loaded while the load trigger is high. The PLL is powered back up, and after a settle interval the block waits for lock. Only then does it switch the output clock back to the PLL and leave bypass. Every step changes one field and leaves every other bit of the word as it was.

The lock wait has a bound. If no lock is seen within the poll limit, the sequence still completes and a sticky timeout flag is set, which the next start clears. While the sequencer is idle, software-style access is possible through two 32-bit halves of the word. A caller starts a reconfiguration, waits for the one-cycle done pulse, and then reads the timeout flag to learn whether the PLL locked.

Top module: `pll_reconfig_seq`

## Requirements
- R1: Field layout of the 64-bit word: output divider bits 6:0, loop multiplier bits 29:21, reference divider bits 38:32, lock status bit 39, output select bit 40, load trigger bit 43, bypass bit 44, power-down bit 45. Each field is driven unchanged to its PLL output port.
- R2: While idle and with no start, a host write stores wr_data into the low half (bits 31:0) when wr_hi=0, or into the high half (bits 63:32) when wr_hi=1. Bit 39 is read-only and shows pll_locked_in as sampled one clock earlier.
- R3: A start pulse while idle latches the three new divider values, and busy is high from the next cycle. A start pulse or host write that arrives while busy has no effect.
- R4: Counting edges from the accepting edge, edge 1 sets bypass, edge 2 clears output select, edge 3 sets power-down, edge 4 sets the load trigger, edge 5 writes all three dividers, edge 6 clears the load trigger and edge 7 clears power-down.
- R5: Each sequence step changes only its own field. All other bits, reserved bits included, keep their value for the whole sequence.
- R6: After power-up the block waits SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US cycles before the first lock poll.
- R7: The lock bit is polled once per cycle, and the sequence proceeds on the first poll that sees it set.
- R8: If POLL_MAX polls see no lock, the sequence proceeds anyway and lock_timeout is set. lock_timeout stays set until the next accepted start clears it.
- R9: After the lock wait, output select is set on one edge and bypass is cleared on the next. On that final edge done pulses high for exactly one cycle and busy falls.
- R10: After reset the word is all zero apart from the sampled lock bit, and busy, done and lock_timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reconfiguration |
| new_div_ref | input | 7 | Reference divider to apply |
| new_loop_mul | input | 9 | Loop multiplier to apply |
| new_div_out | input | 7 | Output divider to apply |
| wr_en | input | 1 | Host half-word write strobe |
| wr_hi | input | 1 | 0 selects bits 31:0, 1 selects bits 63:32 |
| wr_data | input | 32 | Host write data |
| pll_locked_in | input | 1 | Lock indication from the PLL |
| ctrl_word | output | 64 | Current control word |
| pll_div_out | output | 7 | Output divider field |
| pll_loop_mul | output | 9 | Loop multiplier field |
| pll_div_ref | output | 7 | Reference divider field |
| pll_out_sel | output | 1 | Output clock select field |
| pll_load | output | 1 | Parameter load trigger field |
| pll_bypass | output | 1 | Bypass field |
| pll_pwrdn | output | 1 | Power-down field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lock_timeout | output | 1 | Poll limit reached without lock |

## Verification
Edges are counted from the one that accepts start. Step k of the ordered sequence appears on the word after edge k, for k from 1 to 7. The first poll happens on edge 8+SETTLE_CYC. A lock input raised after edge j reaches bit 39 one edge later and is seen by the poll one edge after that. So done is due on edge 10+SETTLE_CYC+m, where m = max(0, j+2-(8+SETTLE_CYC)), or on edge 9+SETTLE_CYC+POLL_MAX when the limit runs out. The bench drives and samples on falling edges, recomputes the expected word after every rising edge, and sweeps j over every position through the limit.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = 32;
    localparam int DOUT_LSB = 0;
    localparam int DOUT_W   = 7;
    localparam int LOOP_LSB = 21;
    localparam int LOOP_W   = 9;
    localparam int DREF_LSB = 32;
    localparam int DREF_W   = 7;
    localparam int LOCK_BIT = 39;
    localparam int SEL_BIT  = 40;
    localparam int LOAD_BIT = 43;
    localparam int BYP_BIT  = 44;
    localparam int PDN_BIT  = 45;

    typedef struct packed {
        logic [DREF_W-1:0] div_ref;
        logic [LOOP_W-1:0] loop_mul;
        logic [DOUT_W-1:0] div_out;
    } div_set_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_BYP_ON, ST_SEL_OFF, ST_PDN_ON, ST_LOAD_ON, ST_DIV_WR,
        ST_LOAD_OFF, ST_PDN_OFF, ST_SETTLE, ST_POLL, ST_SEL_ON, ST_BYP_OFF
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_NONE, OP_BYP_SET, OP_BYP_CLR, OP_SEL_SET, OP_SEL_CLR,
        OP_PDN_SET, OP_PDN_CLR, OP_LOAD_SET, OP_LOAD_CLR, OP_DIV_WR
    } step_op_e;

    // Mask of bits that no sequence step owns.
    function automatic logic [WORD_W-1:0] spare_mask();
        logic [WORD_W-1:0] m;
        m = '1;
        m[DOUT_LSB +: DOUT_W] = '0;
        m[LOOP_LSB +: LOOP_W] = '0;
        m[DREF_LSB +: DREF_W] = '0;
        m[LOCK_BIT] = 1'b0;
        m[SEL_BIT]  = 1'b0;
        m[LOAD_BIT] = 1'b0;
        m[BYP_BIT]  = 1'b0;
        m[PDN_BIT]  = 1'b0;
        return m;
    endfunction

    // Read-modify-write of one field; every other bit passes through.
    function automatic logic [WORD_W-1:0] apply_step(
        input logic [WORD_W-1:0] w,
        input step_op_e          op,
        input div_set_t          d
    );
        logic [WORD_W-1:0] r;
        r = w;
        case (op)
            OP_BYP_SET:  r[BYP_BIT]  = 1'b1;
            OP_BYP_CLR:  r[BYP_BIT]  = 1'b0;
            OP_SEL_SET:  r[SEL_BIT]  = 1'b1;
            OP_SEL_CLR:  r[SEL_BIT]  = 1'b0;
            OP_PDN_SET:  r[PDN_BIT]  = 1'b1;
            OP_PDN_CLR:  r[PDN_BIT]  = 1'b0;
            OP_LOAD_SET: r[LOAD_BIT] = 1'b1;
            OP_LOAD_CLR: r[LOAD_BIT] = 1'b0;
            OP_DIV_WR: begin
                r[DOUT_LSB +: DOUT_W] = d.div_out;
                r[LOOP_LSB +: LOOP_W] = d.loop_mul;
                r[DREF_LSB +: DREF_W] = d.div_ref;
            end
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pll_seq_ctrlreg.sv
module pll_seq_ctrlreg
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_hi,
    input  logic [HALF_W-1:0] host_data,
    input  step_op_e          op,
    input  div_set_t          divs,
    input  logic              locked_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] after_host;
    logic [WORD_W-1:0] word_d;

    always_comb begin
        after_host = word;
        if (host_we) begin
            if (host_hi) begin
                after_host[WORD_W-1:HALF_W] = host_data;
            end else begin
                after_host[HALF_W-1:0] = host_data;
            end
        end
        word_d = apply_step(after_host, op, divs);
        word_d[LOCK_BIT] = locked_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else begin
            word <= word_d;
        end
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 100,
    parameter int POLL_MAX   = 2000,
    parameter int CNT_W      = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             lock_seen,
    input  logic [CNT_W-1:0] cnt,
    output step_op_e         op,
    output logic             tmr_clr,
    output logic             tmr_inc,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_MAX - 1);

    seq_state_e state, state_d;
    logic       finish;
    logic       give_up;

    always_comb begin
        state_d = state;
        op      = OP_NONE;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        finish  = 1'b0;
        give_up = 1'b0;
        case (state)
            ST_IDLE:     if (start) state_d = ST_BYP_ON;
            ST_BYP_ON:   begin op = OP_BYP_SET;  state_d = ST_SEL_OFF;  end
            ST_SEL_OFF:  begin op = OP_SEL_CLR;  state_d = ST_PDN_ON;   end
            ST_PDN_ON:   begin op = OP_PDN_SET;  state_d = ST_LOAD_ON;  end
            ST_LOAD_ON:  begin op = OP_LOAD_SET; state_d = ST_DIV_WR;   end
            ST_DIV_WR:   begin op = OP_DIV_WR;   state_d = ST_LOAD_OFF; end
            ST_LOAD_OFF: begin op = OP_LOAD_CLR; state_d = ST_PDN_OFF;  end
            ST_PDN_OFF: begin
                op      = OP_PDN_CLR;
                tmr_clr = 1'b1;
                state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt == SETTLE_LAST) begin
                    tmr_clr = 1'b1;
                    state_d = ST_POLL;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_POLL: begin
                if (lock_seen) begin
                    tmr_clr = 1'b1;
                    state_d = ST_SEL_ON;
                end else if (cnt == POLL_LAST) begin
                    tmr_clr = 1'b1;
                    give_up = 1'b1;
                    state_d = ST_SEL_ON;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_SEL_ON:   begin op = OP_SEL_SET; state_d = ST_BYP_OFF; end
            ST_BYP_OFF: begin
                op      = OP_BYP_CLR;
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            state <= state_d;
            done  <= finish;
            if (state == ST_IDLE && start) begin
                timeout <= 1'b0;
            end else if (give_up) begin
                timeout <= 1'b1;
            end
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 2,
    parameter int POLL_MAX  = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DREF_W-1:0]   new_div_ref,
    input  logic [LOOP_W-1:0]   new_loop_mul,
    input  logic [DOUT_W-1:0]   new_div_out,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                pll_locked_in,
    output logic [WORD_W-1:0]   ctrl_word,
    output logic [DOUT_W-1:0]   pll_div_out,
    output logic [LOOP_W-1:0]   pll_loop_mul,
    output logic [DREF_W-1:0]   pll_div_ref,
    output logic                pll_out_sel,
    output logic                pll_load,
    output logic                pll_bypass,
    output logic                pll_pwrdn,
    output logic                busy,
    output logic                done,
    output logic                lock_timeout
);
    localparam int SETTLE_RAW = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int CNT_MAX    = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    div_set_t         divs_q;
    step_op_e         op;
    logic             tmr_clr, tmr_inc;
    logic [CNT_W-1:0] cnt;
    logic             host_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            divs_q <= '0;
        end else if (!busy && start) begin
            divs_q <= '{div_ref: new_div_ref, loop_mul: new_loop_mul, div_out: new_div_out};
        end
    end

    assign host_we = wr_en && !busy && !start;

    pll_seq_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .POLL_MAX   (POLL_MAX),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .lock_seen (ctrl_word[LOCK_BIT]),
        .cnt       (cnt),
        .op        (op),
        .tmr_clr   (tmr_clr),
        .tmr_inc   (tmr_inc),
        .busy      (busy),
        .done      (done),
        .timeout   (lock_timeout)
    );

    pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .inc (tmr_inc),
        .cnt (cnt)
    );

    pll_seq_ctrlreg u_reg (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_hi   (wr_hi),
        .host_data (wr_data),
        .op        (op),
        .divs      (divs_q),
        .locked_in (pll_locked_in),
        .word      (ctrl_word)
    );

    assign pll_div_out  = ctrl_word[DOUT_LSB +: DOUT_W];
    assign pll_loop_mul = ctrl_word[LOOP_LSB +: LOOP_W];
    assign pll_div_ref  = ctrl_word[DREF_LSB +: DREF_W];
    assign pll_out_sel  = ctrl_word[SEL_BIT];
    assign pll_load     = ctrl_word[LOAD_BIT];
    assign pll_bypass   = ctrl_word[BYP_BIT];
    assign pll_pwrdn    = ctrl_word[PDN_BIT];
endmodule

// File: rtl/pll_reconfig_seq_chk.sv
module pll_reconfig_seq_chk
    import pll_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] ctrl_word,
    input logic [DOUT_W-1:0] pll_div_out,
    input logic [LOOP_W-1:0] pll_loop_mul,
    input logic [DREF_W-1:0] pll_div_ref,
    input logic              pll_out_sel,
    input logic              pll_load,
    input logic              pll_bypass,
    input logic              pll_pwrdn,
    input logic              busy,
    input logic              done,
    input logic              lock_timeout
);
    localparam logic [WORD_W-1:0] SPARE = spare_mask();

    AST_SPARE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((ctrl_word & SPARE) == ($past(ctrl_word) & SPARE))); // R5

    AST_DIVS_ONLY_UNDER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && !pll_load) |=> $stable({pll_div_ref, pll_loop_mul, pll_div_out})); // R4

    AST_LOAD_NEEDS_SAFE: assert property (@(posedge clk) disable iff (rst)
        (busy && pll_load) |-> (pll_pwrdn && pll_bypass)); // R4

    AST_PDN_AFTER_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(pll_pwrdn)) |-> (pll_bypass && !pll_out_sel)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_FINAL_STATE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && pll_out_sel && !pll_bypass && !pll_pwrdn && !pll_load)); // R9

    AST_TIMEOUT_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_timeout) |-> busy); // R8
endmodule

bind pll_reconfig_seq pll_reconfig_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_word    (ctrl_word),
    .pll_div_out  (pll_div_out),
    .pll_loop_mul (pll_loop_mul),
    .pll_div_ref  (pll_div_ref),
    .pll_out_sel  (pll_out_sel),
    .pll_load     (pll_load),
    .pll_bypass   (pll_bypass),
    .pll_pwrdn    (pll_pwrdn),
    .busy         (busy),
    .done         (done),
    .lock_timeout (lock_timeout)
);

// File: tb/pll_reconfig_seq_bench.sv
module pll_reconfig_seq_bench;
    localparam int S = 10;   // settle cycles for 5 MHz x 2 us
    localparam int P = 8;    // poll limit

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  new_div_ref = '0;
    logic [8:0]  new_loop_mul = '0;
    logic [6:0]  new_div_out = '0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pll_locked_in = 1'b0;
    logic [63:0] ctrl_word;
    logic [6:0]  pll_div_out, pll_div_ref;
    logic [8:0]  pll_loop_mul;
    logic        pll_out_sel, pll_load, pll_bypass, pll_pwrdn;
    logic        busy, done, lock_timeout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [63:0] base = '0;
    localparam logic [63:0] NOLOCK = ~(64'd1 << 39);

    always #10 clk = ~clk;

    pll_reconfig_seq #(.CLK_HZ(5_000_000), .SETTLE_US(2), .POLL_MAX(P)) u_pll_reconfig_seq (
        .clk(clk), .rst(rst), .start(start),
        .new_div_ref(new_div_ref), .new_loop_mul(new_loop_mul), .new_div_out(new_div_out),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .pll_locked_in(pll_locked_in),
        .ctrl_word(ctrl_word), .pll_div_out(pll_div_out), .pll_loop_mul(pll_loop_mul),
        .pll_div_ref(pll_div_ref), .pll_out_sel(pll_out_sel), .pll_load(pll_load),
        .pll_bypass(pll_bypass), .pll_pwrdn(pll_pwrdn), .busy(busy), .done(done),
        .lock_timeout(lock_timeout)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(input bit hi, input logic [31:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (hi) base[63:32] = d; else base[31:0] = d;
        base[39] = 1'b0;
    endtask

    function automatic logic [63:0] exp_word(input int n, input int dn,
                                             input logic [6:0] dr, input logic [8:0] lm,
                                             input logic [6:0] dout);
        logic [63:0] w;
        w = base;
        if (n >= 1) w[44] = 1'b1;
        if (n >= 2) w[40] = 1'b0;
        if (n >= 3) w[45] = 1'b1;
        if (n >= 4) w[43] = 1'b1;
        if (n >= 5) begin w[6:0] = dout; w[29:21] = lm; w[38:32] = dr; end
        if (n >= 6) w[43] = 1'b0;
        if (n >= 7) w[45] = 1'b0;
        if (n >= dn - 1) w[40] = 1'b1;
        if (n >= dn) w[44] = 1'b0;
        return w;
    endfunction

    // j: lock input raised after edge j (0 = never). intr: poke start/write mid-sequence.
    task automatic run_seq(input int j, input logic [6:0] dr, input logic [8:0] lm,
                           input logic [6:0] dout, input bit intr);
        int m, dn;
        bit etout;
        m = (j == 0) ? P : ((j + 2 - (8 + S)) > 0 ? (j + 2 - (8 + S)) : 0);
        if (m < P) begin dn = 10 + S + m; etout = 1'b0; end
        else begin dn = 9 + S + P; etout = 1'b1; end
        pll_locked_in = 1'b0;
        start = 1'b1; new_div_ref = dr; new_loop_mul = lm; new_div_out = dout;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= dn + 1; n++) begin
            @(negedge clk);
            if (j != 0 && n == j) pll_locked_in = 1'b1;
            if (intr && n == 3) begin
                start = 1'b1; new_div_ref = ~dr; new_loop_mul = ~lm; new_div_out = ~dout;
                wr_en = 1'b1; wr_hi = 1'b0; wr_data = 32'hFFFF_FFFF;
            end
            if (intr && n == 4) begin start = 1'b0; wr_en = 1'b0; end
            if (n == 1) chk("R8 timeout cleared by start", {63'd0, lock_timeout}, 64'd0);
            if (n <= 7) chk("R4 R5 ordered step word", ctrl_word & NOLOCK,
                            exp_word(n, dn, dr, lm, dout));
            else if (n >= dn - 1) chk("R7 R9 closing word", ctrl_word & NOLOCK,
                                      exp_word(n, dn, dr, lm, dout));
            else if (n == 7 + S) chk("R6 settle holds word", ctrl_word & NOLOCK,
                                     exp_word(n, dn, dr, lm, dout));
            if (n == dn - 1) chk("R3 R9 busy before done", {62'd0, busy, done}, 64'd2);
            if (n == dn) begin
                chk("R7 R8 R9 done pulse, busy low, timeout", {61'd0, busy, done, lock_timeout},
                    {61'd0, 1'b0, 1'b1, etout});
                chk("R1 field outputs", {pll_div_ref, pll_loop_mul, pll_div_out,
                    pll_out_sel, pll_load, pll_bypass, pll_pwrdn},
                    {dr, lm, dout, 1'b1, 1'b0, 1'b0, 1'b0});
            end
            if (n == dn + 1) chk("R8 R9 done one cycle, flag held", {62'd0, done, lock_timeout},
                                 {62'd0, 1'b0, etout});
        end
        base = exp_word(dn, dn, dr, lm, dout);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset word", ctrl_word, 64'd0);
        chk("R10 reset flags", {61'd0, busy, done, lock_timeout}, 64'd0);
        // R2: halves and read-only lock bit
        host_write(1'b0, 32'hA5C3_0F96);
        chk("R2 low half write", ctrl_word, base);
        pll_locked_in = 1'b1;
        host_write(1'b1, 32'h8255_0000 | 32'h0000_0180);
        chk("R2 high half, bit39 follows lock", ctrl_word, base | (64'd1 << 39));
        pll_locked_in = 1'b0;
        @(negedge clk);
        chk("R2 bit39 cleared by lock input", {63'd0, ctrl_word[39]}, 64'd0);
        // ensure select set so its clearing is visible
        host_write(1'b1, base[63:32] | 32'h0000_0100);
        // lock-position sweep, R6 R7 R8
        for (int j = 0; j <= 8 + S + P; j++) begin
            run_seq(j, 7'(3 + j), 9'(49 + 7 * j), 7'(11 + j), 1'b0);
        end
        // R3: start and write while busy are ignored
        run_seq(20, 7'd5, 9'd117, 7'd16, 1'b1);
        run_seq(0, 7'd4, 9'd95, 7'd8, 1'b1);
        run_seq(12, 7'd3, 9'd160, 7'd63, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule